// File: doc/BRIEF.md
# Codec Command and Response Ring Engine

This block sits between a host register port and a codec link. The host writes 32-bit codec commands into a 256-slot command ring and publishes them by moving a write pointer. The engine then hands the commands, one at a time, to a valid/ready command port. In the other direction, each response the link delivers is stored as a 64-bit entry in a 256-slot response ring. The entry carries the codec address and a flag that marks an unsolicited response, so software can tell these apart from answers to its own commands.

All ring pointers name the last valid entry, not the next free slot. A producer first steps its pointer by one, modulo 256, and then uses that slot. The response side raises a status bit after a programmable number of stored responses. It flags an overrun when the ring is full, and it drives an interrupt line gated by an enable bit. Both rings live in internal memories. The host writes command slots and reads slots of either ring through a small memory window.

The register selector `reg_addr` decodes as follows: 0 command write pointer, 1 command read pointer, 2 command control, 3 response write pointer, 4 response count threshold, 5 response control, 6 response status, 7 host response read pointer. In both control registers, bit 1 is the run bit. In response control, bit 0 is the interrupt enable.

Top module: `codec_ring_engine`

## Requirements
- R1: When command run (reg 2 bit 1) is set and the read pointer (reg 1) differs from the write pointer (reg 0), the engine presents the command in slot read-pointer+1 unaltered on `cmd_word`. The read pointer takes that slot index, so commands leave in ring order, and fetching stops when the two pointers are equal. The field layout is codec address in bits 31:28, direct flag in bit 27, node from bit 20, verb from bit 8 and payload in bits 7:0.
- R2: Both pointers wrap from 255 to 0.
- R3: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and `cmd_word` hold their values.
- R4: Clearing the command run bit lets the command already on the port complete, and no further command is fetched.
- R5: Writing a value with bit 15 set to reg 1 or reg 3 clears that pointer to 0, but only while its ring is stopped: run clear and, for commands, nothing on the port. Otherwise the write has no effect.
- R6: With response run (reg 5 bit 1) set, each response is written to slot write-pointer+1 and reg 3 advances to that slot. The lower word of the entry is the response data. The upper word holds the codec address in bits 3:0, the unsolicited flag in bit 4, and zero elsewhere.
- R7: With response run clear, incoming responses change neither the ring nor the status.
- R8: Status bit 0 (reg 6) is set when the number of stored responses since the last restart reaches the threshold (reg 4). The counter then restarts. A threshold of 0 means 256.
- R9: Writing reg 4 restarts the response counter.
- R10: If the slot after the response write pointer equals the host read pointer (reg 7), the response is dropped, the pointer stays put, and status bit 2 is set.
- R11: Status bits clear only when written with 1. A written 0 leaves them unchanged.
- R12: `irq` is high exactly when interrupt enable (reg 5 bit 0) is set and status bit 0 or bit 2 is set.
- R13: After reset every register reads 0, and `cmd_valid` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register selector |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| mem_wr | input | 1 | Command ring slot write strobe |
| mem_sel | input | 1 | Window ring select: 0 command, 1 response |
| mem_idx | input | 8 | Window slot index |
| mem_wdata | input | 32 | Command word to store |
| mem_rdata | output | 64 | Slot contents (command zero-extended) |
| cmd_valid | output | 1 | Command offered to the link |
| cmd_ready | input | 1 | Link accepts the command |
| cmd_word | output | 32 | Command word |
| rsp_valid | input | 1 | Response arrives this cycle |
| rsp_data | input | 32 | Response data |
| rsp_unsol | input | 1 | Response is unsolicited |
| rsp_codec | input | 4 | Codec address of the response |
| irq | output | 1 | Response interrupt |

## Verification
The assertions take for granted that the host writes a pointer reset only while the ring is stopped. They also assume the link keeps `cmd_ready` driven and pulses `rsp_valid` for exactly one cycle per response. The stimulus follows these rules. Command slots are written only beyond the published write pointer. The response ring is drained by moving the host read pointer before each response, except in the deliberate overrun case. The long sweeps push more than 256 entries through each ring, so both pointers wrap, and they cycle the ready pattern so backpressure lands on every phase of a fetch.

// File: rtl/codec_ring_pkg.sv
// Shared register selectors and bit positions for the codec ring engine.
package codec_ring_pkg;
    typedef enum logic [2:0] {
        SEL_CWP   = 3'd0,
        SEL_CRP   = 3'd1,
        SEL_CCTL  = 3'd2,
        SEL_RWP   = 3'd3,
        SEL_RTHR  = 3'd4,
        SEL_RCTL  = 3'd5,
        SEL_RSTAT = 3'd6,
        SEL_RHRP  = 3'd7
    } reg_sel_e;

    localparam int RUN_BIT     = 1;
    localparam int IEN_BIT     = 0;
    localparam int PTR_CLR_BIT = 15;
    localparam int ST_RESP_BIT = 0;
    localparam int ST_OVR_BIT  = 2;
    localparam int UNSOL_BIT   = 4;
endpackage

// File: rtl/ring_store.sv
// Ring storage: one synchronous write port and two combinational read ports.
// Assumes the writer never targets a slot in the same cycle it expects to read it back.
module ring_store #(
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [WIDTH-1:0]  rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [WIDTH-1:0]  rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] slots [DEPTH];

    // Store one entry per write strobe.
    always_ff @(posedge clk) begin
        if (we) slots[waddr] <= wdata;
    end

    assign rdata_a = slots[raddr_a];
    assign rdata_b = slots[raddr_b];
endmodule

// File: rtl/cmd_fetch.sv
// Command fetcher: walks the read pointer toward the host write pointer and
// offers each fetched word on a valid/ready port. The pointer names the last
// slot sent. Assumes the clear request arrives only as a one-cycle strobe.
module cmd_fetch #(
    parameter int CW     = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [ADDR_W-1:0] wp,
    input  logic              clr_req,
    output logic [ADDR_W-1:0] fetch_idx,
    input  logic [CW-1:0]     fetch_word,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [CW-1:0]     cmd_word,
    output logic [ADDR_W-1:0] rp,
    output logic              stopped
);
    logic [ADDR_W-1:0] rp_q;
    logic              valid_q;
    logic [CW-1:0]     word_q;
    logic              launch;

    assign fetch_idx = rp_q + ADDR_W'(1);
    assign stopped   = !run && !valid_q;
    assign launch    = run && (rp_q != wp) && (!valid_q || cmd_ready);

    // Fetch the next slot when the port is free, drop valid on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_q    <= '0;
            valid_q <= 1'b0;
            word_q  <= '0;
        end else begin
            if (launch) begin
                word_q  <= fetch_word;
                valid_q <= 1'b1;
                rp_q    <= fetch_idx;
            end else if (cmd_ready) begin
                valid_q <= 1'b0;
            end
            if (clr_req && stopped) rp_q <= '0;
        end
    end

    assign cmd_valid = valid_q;
    assign cmd_word  = word_q;
    assign rp        = rp_q;

    // R1: the read pointer only steps by one slot or returns to zero
    a_r1_rp_steps: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rp_q) |-> (rp_q == $past(rp_q) + ADDR_W'(1)) || (rp_q == '0));
    // R3: an unaccepted command is held unchanged
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_word)));
    // R4: nothing new is offered once stopped
    a_r4_no_fetch_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cmd_valid) |=> !cmd_valid);
endmodule

// File: rtl/rsp_commit.sv
// Response committer: forms a 64-bit ring entry from each arriving response,
// writes it at the slot after the write pointer, counts stored entries against
// a threshold and detects overrun against the host read pointer.
// Assumes each response is presented for exactly one cycle.
module rsp_commit #(
    parameter int DW     = 32,
    parameter int CAW    = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [ADDR_W-1:0] host_rp,
    input  logic [ADDR_W-1:0] thr,
    input  logic              thr_wr,
    input  logic              clr_req,
    input  logic              in_valid,
    input  logic [DW-1:0]     in_data,
    input  logic              in_unsol,
    input  logic [CAW-1:0]    in_codec,
    output logic              ring_we,
    output logic [ADDR_W-1:0] ring_waddr,
    output logic [2*DW-1:0]   ring_wdata,
    output logic [ADDR_W-1:0] wp,
    output logic              resp_hit,
    output logic              ovr_hit
);
    import codec_ring_pkg::*;

    localparam int CNT_W = ADDR_W + 1;

    logic [ADDR_W-1:0] wp_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  limit;
    logic [CNT_W-1:0]  cnt_nxt;
    logic [DW-1:0]     upper;
    logic              full;
    logic              accept;

    assign ring_waddr = wp_q + ADDR_W'(1);
    assign full       = (ring_waddr == host_rp);
    assign accept     = in_valid && run && !full;
    assign ovr_hit    = in_valid && run && full;
    assign limit      = (thr == '0) ? CNT_W'(1 << ADDR_W) : CNT_W'(thr);
    assign cnt_nxt    = cnt_q + CNT_W'(1);
    assign resp_hit   = accept && (cnt_nxt == limit);

    // Build the upper word: codec address low, unsolicited flag above it.
    always_comb begin
        upper                = '0;
        upper[CAW-1:0]       = in_codec;
        upper[UNSOL_BIT]     = in_unsol;
    end

    assign ring_we    = accept;
    assign ring_wdata = {upper, in_data};

    // Advance the write pointer and the threshold counter per stored entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (accept) begin
                wp_q  <= ring_waddr;
                cnt_q <= resp_hit ? '0 : cnt_nxt;
            end
            if (thr_wr) cnt_q <= '0;
            if (clr_req && !run) wp_q <= '0;
        end
    end

    assign wp = wp_q;

    // R10: a dropped response leaves the write pointer where it was
    a_r10_drop_keeps_wp: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_hit |=> $stable(wp_q));
    // R6: the write pointer only steps by one slot or returns to zero
    a_r6_wp_steps: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wp_q) |-> (wp_q == $past(wp_q) + ADDR_W'(1)) || (wp_q == '0));
endmodule

// File: rtl/codec_ring_engine.sv
// Top of the codec ring engine: host register file, memory window, command
// fetcher and response committer. Assumes a single host master that issues at
// most one register or memory access per cycle.
module codec_ring_engine #(
    parameter int ADDR_W = 8,
    parameter int CW     = 32,
    parameter int CAW    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              mem_wr,
    input  logic              mem_sel,
    input  logic [ADDR_W-1:0] mem_idx,
    input  logic [CW-1:0]     mem_wdata,
    output logic [2*CW-1:0]   mem_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [CW-1:0]     cmd_word,
    input  logic              rsp_valid,
    input  logic [CW-1:0]     rsp_data,
    input  logic              rsp_unsol,
    input  logic [CAW-1:0]    rsp_codec,
    output logic              irq
);
    import codec_ring_pkg::*;

    localparam int RW = 2 * CW;

    reg_sel_e          sel;
    logic [ADDR_W-1:0] cwp_q, rthr_q, rhrp_q;
    logic              crun_q, rrun_q, rien_q;
    logic              st_resp_q, st_ovr_q;
    logic              wr_sel [8];

    logic [ADDR_W-1:0] fetch_idx, crp, rwp, rsp_waddr;
    logic [CW-1:0]     fetch_word, cmd_peek;
    logic [RW-1:0]     rsp_wdata, rsp_peek;
    logic              rsp_we, resp_hit, ovr_hit, cmd_stopped;

    assign sel = reg_sel_e'(reg_addr);

    // One write strobe per register selector.
    for (genvar g = 0; g < 8; g++) begin : g_wsel
        assign wr_sel[g] = reg_wr && (reg_addr == 3'(g));
    end

    // Host-owned registers and write-one-to-clear status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp_q     <= '0;
            rthr_q    <= '0;
            rhrp_q    <= '0;
            crun_q    <= 1'b0;
            rrun_q    <= 1'b0;
            rien_q    <= 1'b0;
            st_resp_q <= 1'b0;
            st_ovr_q  <= 1'b0;
        end else begin
            if (wr_sel[SEL_CWP])  cwp_q  <= reg_wdata[ADDR_W-1:0];
            if (wr_sel[SEL_RTHR]) rthr_q <= reg_wdata[ADDR_W-1:0];
            if (wr_sel[SEL_RHRP]) rhrp_q <= reg_wdata[ADDR_W-1:0];
            if (wr_sel[SEL_CCTL]) crun_q <= reg_wdata[RUN_BIT];
            if (wr_sel[SEL_RCTL]) begin
                rrun_q <= reg_wdata[RUN_BIT];
                rien_q <= reg_wdata[IEN_BIT];
            end
            st_resp_q <= (st_resp_q && !(wr_sel[SEL_RSTAT] && reg_wdata[ST_RESP_BIT])) || resp_hit;
            st_ovr_q  <= (st_ovr_q  && !(wr_sel[SEL_RSTAT] && reg_wdata[ST_OVR_BIT]))  || ovr_hit;
        end
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_CWP:   reg_rdata[ADDR_W-1:0] = cwp_q;
            SEL_CRP:   reg_rdata[ADDR_W-1:0] = crp;
            SEL_CCTL:  reg_rdata[RUN_BIT]    = crun_q;
            SEL_RWP:   reg_rdata[ADDR_W-1:0] = rwp;
            SEL_RTHR:  reg_rdata[ADDR_W-1:0] = rthr_q;
            SEL_RCTL:  begin
                reg_rdata[RUN_BIT] = rrun_q;
                reg_rdata[IEN_BIT] = rien_q;
            end
            SEL_RSTAT: begin
                reg_rdata[ST_RESP_BIT] = st_resp_q;
                reg_rdata[ST_OVR_BIT]  = st_ovr_q;
            end
            SEL_RHRP:  reg_rdata[ADDR_W-1:0] = rhrp_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign mem_rdata = mem_sel ? rsp_peek : {{CW{1'b0}}, cmd_peek};
    assign irq       = rien_q && (st_resp_q || st_ovr_q);

    ring_store #(.WIDTH(CW), .ADDR_W(ADDR_W)) u_cmd_ring (
        .clk(clk), .we(mem_wr), .waddr(mem_idx), .wdata(mem_wdata),
        .raddr_a(fetch_idx), .rdata_a(fetch_word),
        .raddr_b(mem_idx), .rdata_b(cmd_peek)
    );

    ring_store #(.WIDTH(RW), .ADDR_W(ADDR_W)) u_rsp_ring (
        .clk(clk), .we(rsp_we), .waddr(rsp_waddr), .wdata(rsp_wdata),
        .raddr_a(mem_idx), .rdata_a(rsp_peek),
        .raddr_b(rwp), .rdata_b()
    );

    cmd_fetch #(.CW(CW), .ADDR_W(ADDR_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .run(crun_q), .wp(cwp_q),
        .clr_req(wr_sel[SEL_CRP] && reg_wdata[PTR_CLR_BIT]),
        .fetch_idx(fetch_idx), .fetch_word(fetch_word),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
        .rp(crp), .stopped(cmd_stopped)
    );

    rsp_commit #(.DW(CW), .CAW(CAW), .ADDR_W(ADDR_W)) u_commit (
        .clk(clk), .rst_n(rst_n), .run(rrun_q), .host_rp(rhrp_q),
        .thr(rthr_q), .thr_wr(wr_sel[SEL_RTHR]),
        .clr_req(wr_sel[SEL_RWP] && reg_wdata[PTR_CLR_BIT]),
        .in_valid(rsp_valid), .in_data(rsp_data), .in_unsol(rsp_unsol), .in_codec(rsp_codec),
        .ring_we(rsp_we), .ring_waddr(rsp_waddr), .ring_wdata(rsp_wdata),
        .wp(rwp), .resp_hit(resp_hit), .ovr_hit(ovr_hit)
    );

    // R5: a pointer clear while the command ring is live leaves the pointer alone
    a_r5_clear_when_live: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel[SEL_CRP] && reg_wdata[PTR_CLR_BIT] && !cmd_stopped && !cmd_valid && crp != cwp_q)
        |=> (crp != '0) || $past(crp == ADDR_W'(-1)));
    // R11: status bits never drop without a write of one
    a_r11_w1c_only: assert property (@(posedge clk) disable iff (!rst_n)
        (st_resp_q && !(wr_sel[SEL_RSTAT] && reg_wdata[ST_RESP_BIT])) |=> st_resp_q);
endmodule

// File: tb/tb_codec_ring_engine.sv
module tb_codec_ring_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mem_wr = 1'b0;
    logic        mem_sel = 1'b0;
    logic [7:0]  mem_idx = '0;
    logic [31:0] mem_wdata = '0;
    logic [63:0] mem_rdata;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_word;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;
    logic        rsp_unsol = 1'b0;
    logic [3:0]  rsp_codec = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int k     = 0;
    int cwp_m = 0;
    int rwp_m = 0;
    logic [15:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    codec_ring_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_wr(mem_wr),
        .mem_sel(mem_sel), .mem_idx(mem_idx), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_word(cmd_word), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_unsol(rsp_unsol), .rsp_codec(rsp_codec), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] cw(input int i);
        return 32'(i) * 32'h9E3779B1 ^ 32'h5A5A_0000;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic memw(input int idx, input logic [31:0] d);
        @(negedge clk);
        mem_wr = 1'b1; mem_idx = 8'(idx); mem_wdata = d;
        @(negedge clk);
        mem_wr = 1'b0;
    endtask

    task automatic memr(input logic s, input int idx, output logic [63:0] d);
        @(negedge clk);
        mem_sel = s; mem_idx = 8'(idx);
        #1 d = mem_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Publish n commands and collect them under a rotating ready pattern.
    task automatic send_batch(input int n, input int phase);
        int got;
        int guard;
        logic r;
        for (int i = 0; i < n; i++) memw((cwp_m + 1 + i) % 256, cw(k + i));
        wr(3'd0, 16'((cwp_m + n) % 256));
        got = 0; guard = 0;
        while (got < n && guard < 4000) begin
            @(negedge clk);
            r = ((guard + phase) % 3) != 1;
            if (cmd_valid && r) begin
                chk("R1 command order", {32'b0, cmd_word}, {32'b0, cw(k + got)});
                got++;
            end
            cmd_ready = r;
            guard++;
        end
        chk("R1 batch count", 64'(got), 64'(n));
        k += n;
        cwp_m = (cwp_m + n) % 256;
        idle(4);
        chk("R1 idle after batch", {63'b0, cmd_valid}, 64'd0);
        rd(3'd1, rv);
        chk("R2 read pointer tracks write pointer", 64'(rv), 64'(cwp_m));
    endtask

    // Deliver one response; optionally mark the ring fully consumed first.
    task automatic rsp(input logic [31:0] d, input logic u, input logic [3:0] c, input bit drain);
        if (drain) wr(3'd7, 16'(rwp_m));
        @(negedge clk);
        rsp_valid = 1'b1; rsp_data = d; rsp_unsol = u; rsp_codec = c;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic stat_is(input string req, input logic [15:0] exp);
        rd(3'd6, rv);
        chk(req, 64'(rv), 64'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] mv;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R13: reset values
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), rv);
            chk("R13 register reset", 64'(rv), 64'd0);
        end
        chk("R13 cmd_valid reset", {63'b0, cmd_valid}, 64'd0);
        chk("R13 irq reset", {63'b0, irq}, 64'd0);

        // R1, R2, R3: batches 1..23 push 276 commands through, wrapping the ring
        wr(3'd2, 16'h0002);
        for (int n = 1; n <= 23; n++) send_batch(n, n);

        // R5: clear of the read pointer while running has no effect
        wr(3'd1, 16'h8000);
        rd(3'd1, rv);
        chk("R5 clear ignored while running", 64'(rv), 64'(cwp_m));

        // R3, R4: hold under backpressure, then stop after the in-flight command
        cmd_ready = 1'b0;
        for (int i = 0; i < 3; i++) memw((cwp_m + 1 + i) % 256, cw(k + i));
        wr(3'd0, 16'((cwp_m + 3) % 256));
        idle(3);
        chk("R3 valid held", {63'b0, cmd_valid}, 64'd1);
        chk("R3 word held", {32'b0, cmd_word}, {32'b0, cw(k)});
        wr(3'd2, 16'h0000);
        idle(3);
        chk("R4 in-flight kept", {63'b0, cmd_valid}, 64'd1);
        chk("R4 in-flight word", {32'b0, cmd_word}, {32'b0, cw(k)});
        cmd_ready = 1'b1;
        idle(1);
        chk("R4 accepted", {63'b0, cmd_valid}, 64'd0);
        idle(6);
        chk("R4 no further fetch", {63'b0, cmd_valid}, 64'd0);
        rd(3'd1, rv);
        chk("R4 pointer after stop", 64'(rv), 64'((cwp_m + 1) % 256));

        // R5: clear while stopped zeroes the pointer
        wr(3'd1, 16'h8000);
        rd(3'd1, rv);
        chk("R5 clear while stopped", 64'(rv), 64'd0);
        k += 3;
        cwp_m = 0;
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h0002);
        send_batch(4, 0);

        // R6, R2, R12: 260 responses at threshold 1, wrapping the response ring
        wr(3'd4, 16'd1);
        wr(3'd5, 16'h0003);
        for (int j = 0; j < 260; j++) begin
            logic [31:0] d;
            logic        u;
            logic [3:0]  c;
            d = 32'(j) * 32'h0100_0193 ^ 32'hC3C3_0F0F;
            u = (j % 3) == 0;
            c = 4'(j % 16);
            rsp(d, u, c, 1'b1);
            rwp_m = (rwp_m + 1) % 256;
            rd(3'd3, rv);
            chk("R6 write pointer advance", 64'(rv), 64'(rwp_m));
            memr(1'b1, rwp_m, mv);
            chk("R6 entry layout", mv, {27'b0, u, c, d});
            chk("R12 irq on response", {63'b0, irq}, 64'd1);
            wr(3'd6, 16'h0001);
        end

        // R11: only a written one clears
        rsp(32'h1234_5678, 1'b0, 4'h3, 1'b1);
        rwp_m = (rwp_m + 1) % 256;
        wr(3'd6, 16'h0000);
        stat_is("R11 zero write keeps status", 16'h0001);
        wr(3'd6, 16'h0004);
        stat_is("R11 other bit write keeps status", 16'h0001);
        wr(3'd6, 16'h0001);
        stat_is("R11 one write clears", 16'h0000);

        // R12: enable gating
        wr(3'd5, 16'h0002);
        rsp(32'hAAAA_5555, 1'b1, 4'h1, 1'b1);
        rwp_m = (rwp_m + 1) % 256;
        stat_is("R12 status without enable", 16'h0001);
        chk("R12 irq masked", {63'b0, irq}, 64'd0);
        wr(3'd5, 16'h0003);
        idle(1);
        chk("R12 irq when enabled", {63'b0, irq}, 64'd1);
        wr(3'd6, 16'h0001);
        idle(1);
        chk("R12 irq drops with status", {63'b0, irq}, 64'd0);

        // R8: thresholds 2..6
        for (int t = 2; t <= 6; t++) begin
            wr(3'd4, 16'(t));
            for (int i = 0; i < t - 1; i++) begin
                rsp(32'(i), 1'b0, 4'h2, 1'b1);
                rwp_m = (rwp_m + 1) % 256;
            end
            stat_is("R8 below threshold", 16'h0000);
            rsp(32'hFFFF_0000, 1'b0, 4'h2, 1'b1);
            rwp_m = (rwp_m + 1) % 256;
            stat_is("R8 at threshold", 16'h0001);
            wr(3'd6, 16'h0001);
        end

        // R8: threshold 0 means 256
        wr(3'd4, 16'd0);
        for (int i = 0; i < 255; i++) begin
            rsp(32'(i), 1'b0, 4'h0, 1'b1);
            rwp_m = (rwp_m + 1) % 256;
        end
        stat_is("R8 zero threshold after 255", 16'h0000);
        rsp(32'h0, 1'b0, 4'h0, 1'b1);
        rwp_m = (rwp_m + 1) % 256;
        stat_is("R8 zero threshold after 256", 16'h0001);
        wr(3'd6, 16'h0001);

        // R9: rewriting the threshold restarts the counter
        wr(3'd4, 16'd3);
        for (int i = 0; i < 2; i++) begin
            rsp(32'(i), 1'b0, 4'h5, 1'b1);
            rwp_m = (rwp_m + 1) % 256;
        end
        wr(3'd4, 16'd3);
        for (int i = 0; i < 2; i++) begin
            rsp(32'(i), 1'b0, 4'h5, 1'b1);
            rwp_m = (rwp_m + 1) % 256;
        end
        stat_is("R9 restart on rewrite", 16'h0000);
        rsp(32'h9, 1'b0, 4'h5, 1'b1);
        rwp_m = (rwp_m + 1) % 256;
        stat_is("R9 third after restart", 16'h0001);
        wr(3'd6, 16'h0001);

        // R10: overrun when the ring is full
        wr(3'd4, 16'd1);
        wr(3'd7, 16'((rwp_m + 2) % 256));
        rsp(32'h0BAD_0001, 1'b0, 4'h7, 1'b0);
        rwp_m = (rwp_m + 1) % 256;
        wr(3'd6, 16'h0001);
        memr(1'b1, (rwp_m + 1) % 256, mv);
        rsp(32'h0BAD_0002, 1'b1, 4'h7, 1'b0);
        rd(3'd3, rv);
        chk("R10 pointer kept on overrun", 64'(rv), 64'(rwp_m));
        stat_is("R10 overrun flag", 16'h0004);
        chk("R12 irq on overrun", {63'b0, irq}, 64'd1);
        begin
            logic [63:0] mv2;
            memr(1'b1, (rwp_m + 1) % 256, mv2);
            chk("R10 slot untouched", mv2, mv);
        end
        wr(3'd6, 16'h0004);
        stat_is("R11 overrun cleared", 16'h0000);

        // R5: response pointer clear ignored while running
        wr(3'd3, 16'h8000);
        rd(3'd3, rv);
        chk("R5 response clear ignored", 64'(rv), 64'(rwp_m));

        // R7: responses ignored while stopped
        wr(3'd5, 16'h0000);
        rsp(32'hDEAD_BEEF, 1'b0, 4'h1, 1'b1);
        rd(3'd3, rv);
        chk("R7 pointer unchanged when stopped", 64'(rv), 64'(rwp_m));
        stat_is("R7 status unchanged when stopped", 16'h0000);

        // R5: response pointer clear while stopped
        wr(3'd3, 16'h8000);
        rd(3'd3, rv);
        chk("R5 response clear while stopped", 64'(rv), 64'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule